// File: doc/BRIEF.md
# Validity-Tracked Handover Memory

This block is a shared word memory placed between one producing engine and one consuming engine. Every stored word carries a hardware flag that says whether it holds fresh, unconsumed data. A producer store sets the flag. A consumer load checks the flags of all the words it asks for. When every requested word is fresh, the load returns the data and clears those flags, so each value is delivered once. Neither side polls a software semaphore, and neither side sends a message to the other.

A consumer request names a start word and a length from one to eight words. All of the words come from the same row, and the column index wraps around inside that row. The whole group is checked and handed over together, one cycle after the request is granted, on a wide lane bus. The same path therefore serves single-word loads, short bursts and window fetches. If any word in the group is not ready, the request is held off with a stall and nothing changes. A producer store to a word that has not yet been consumed is also held off. This protects unread data from being overwritten.

Top module: `vtm_mem`

## Requirements
- R1: After reset every word flag is invalid, so any consumer request stalls until the producer has stored the words it names.
- R2: A producer store (`wr_req` high) to a word whose flag is invalid is accepted in the same cycle with `wr_stall` low, and the word becomes readable from the next cycle.
- R3: A producer store to a word whose flag is valid raises `wr_stall` in that cycle, and neither the stored data nor the flag changes.
- R4: A consumer request whose words are all valid has `rd_stall` low. On the next cycle `rd_ack` is high for one cycle, and lane i of `rd_data` (bits 32*i+31 down to 32*i) holds the word for group position i. Lanes beyond the group length read zero.
- R5: A granted consumer request clears the flags of exactly the words it returned, so a repeat request for those words stalls.
- R6: If any word in a consumer request is invalid, `rd_stall` is high in that cycle, `rd_ack` is low on the next cycle, and no flag is cleared.
- R7: `rd_len` is a 3-bit field whose value L selects L+1 words. Position i addresses the same row as `rd_addr` (address bits 5..3) at column (`rd_addr[2:0]` + i) mod 8.
- R8: When a store and a request hit the same invalid word in the same cycle, the store completes and the request stalls. The same request repeated in the next cycle is granted and returns the new data.
- R9: `rd_stall` is low whenever `rd_req` is low, and `wr_stall` is low whenever `wr_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer store request |
| wr_addr | input | 6 | Producer word address |
| wr_data | input | 32 | Producer store data |
| wr_stall | output | 1 | Store held off: the target word is still unconsumed |
| rd_req | input | 1 | Consumer request |
| rd_addr | input | 6 | Consumer start word address |
| rd_len | input | 3 | Group length minus one |
| rd_stall | output | 1 | Request held off: at least one word is not ready |
| rd_ack | output | 1 | One-cycle pulse: `rd_data` holds a granted group |
| rd_data | output | 256 | Eight 32-bit lanes of returned words |

## Verification
The bench builds the block with its default parameters: a 64-word store in eight rows of eight words, and a length field that reaches the full row. Because a group can span the whole row, a start column near the end of a row wraps all the way around. A maximum-length group therefore touches every word of one row and no word outside it. The small depth lets the bench sweep all rows for the post-reset stall. It also lets the bench combine partial groups, same-cycle store and request collisions, and overwrite attempts on unconsumed words in a short run.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int VTM_DATA_W = 32;
  localparam int VTM_ADDR_W = 6;
  localparam int VTM_ROW_W  = 3;
  localparam int VTM_LEN_W  = 3;
endpackage

// File: rtl/vtm_lane_gen.sv
module vtm_lane_gen #(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = 3,
  parameter int LEN_W  = 3,
  localparam int LANES = 2 ** LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] lane_addr [LANES],
  output logic [LANES-1:0]  lane_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ROW_W-1:0] col;
    always_comb begin
      col          = rd_addr[ROW_W-1:0] + ROW_W'(i);
      lane_addr[i] = {rd_addr[ADDR_W-1:ROW_W], col};
      lane_en[i]   = ((LEN_W+1)'(i) <= {1'b0, rd_len});
    end

    // R7: an active lane never leaves the start row
    a_r7_same_row: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |-> (lane_addr[i][ADDR_W-1:ROW_W] == rd_addr[ADDR_W-1:ROW_W]));
  end

  // R7: the number of active lanes equals the length field plus one
  a_r7_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) == int'(rd_len) + 1);
endmodule

// File: rtl/vtm_flag_array.sv
module vtm_flag_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] lane_addr [LANES],
  input  logic [LANES-1:0]  lane_en,
  output logic [DEPTH-1:0]  flags_q
);
  logic [DEPTH-1:0] set_vec;
  logic [DEPTH-1:0] clr_vec;
  logic [DEPTH-1:0] flags_d;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_en) set_vec[set_addr] = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (clr_en && lane_en[i]) clr_vec[lane_addr[i]] = 1'b1;
    end
    flags_d = (flags_q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R3: a store is only ever accepted into an invalid word
  a_r3_set_only_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !flags_q[set_addr]);

  // R2: an accepted store leaves its word valid
  a_r2_set_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> flags_q[$past(set_addr)]);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R6: only fully valid groups are ever consumed
    a_r6_clear_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && lane_en[i]) |-> flags_q[lane_addr[i]]);
    // R5: a consumed word is invalid afterwards
    a_r5_clear_marks_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && lane_en[i]) |=> !flags_q[$past(lane_addr[i])]);
  end
endmodule

// File: rtl/vtm_store.sv
module vtm_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       lane_addr [LANES],
  input  logic [LANES-1:0]        lane_en,
  output logic [LANES*DATA_W-1:0] rd_data_q
);
  logic [DATA_W-1:0]       mem [DEPTH];
  logic [LANES*DATA_W-1:0] rd_data_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_data_d = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) rd_data_d[i*DATA_W +: DATA_W] = mem[lane_addr[i]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_d;
  end
endmodule

// File: rtl/vtm_mem.sv
module vtm_mem
  import vtm_pkg::*;
#(
  parameter int DATA_W = VTM_DATA_W,
  parameter int ADDR_W = VTM_ADDR_W,
  parameter int ROW_W  = VTM_ROW_W,
  parameter int LEN_W  = VTM_LEN_W,
  localparam int LANES = 2 ** LEN_W,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_req,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    wr_stall,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LEN_W-1:0]        rd_len,
  output logic                    rd_stall,
  output logic                    rd_ack,
  output logic [LANES*DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [LANES-1:0]  lane_en;
  logic [DEPTH-1:0]  flags_q;
  logic [LANES-1:0]  lane_ok;
  logic              group_ok;
  logic              wr_grant;
  logic              rd_grant;
  logic              rd_ack_d;
  logic              rd_ack_q;

  vtm_lane_gen #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .LEN_W(LEN_W)) i_lane_gen (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_len(rd_len),
    .lane_addr(lane_addr), .lane_en(lane_en)
  );

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_ok[i] = !lane_en[i] || flags_q[lane_addr[i]];
    group_ok = &lane_ok;
    wr_grant = wr_req && !flags_q[wr_addr];
    wr_stall = wr_req && flags_q[wr_addr];
    rd_grant = rd_req && group_ok;
    rd_stall = rd_req && !group_ok;
    rd_ack_d = rd_grant;
  end

  vtm_flag_array #(.ADDR_W(ADDR_W), .LANES(LANES)) i_flags (
    .clk(clk), .rst_n(rst_n), .set_en(wr_grant), .set_addr(wr_addr),
    .clr_en(rd_grant), .lane_addr(lane_addr), .lane_en(lane_en), .flags_q(flags_q)
  );

  vtm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_grant), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_grant), .lane_addr(lane_addr), .lane_en(lane_en), .rd_data_q(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ack_q <= 1'b0;
    else        rd_ack_q <= rd_ack_d;
  end
  assign rd_ack = rd_ack_q;

  // R4: a request without stall is acknowledged on the next cycle
  a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_stall) |=> rd_ack);
  // R6: a stalled request produces no acknowledge
  a_r6_no_ack_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_stall) |=> !rd_ack);
  // R9: stalls only accompany requests
  a_r9_rd_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> rd_req);
  a_r9_wr_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> wr_req);
  // R3: a stalled store leaves its word valid
  a_r3_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_stall && !rd_req) |=> wr_stall || !wr_req || ($past(wr_addr) != wr_addr) || rd_req);
endmodule

// File: tb/test_vtm_mem.sv
module test_vtm_mem;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_req;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;
  logic         wr_stall;
  logic         rd_req;
  logic [5:0]   rd_addr;
  logic [2:0]   rd_len;
  logic         rd_stall;
  logic         rd_ack;
  logic [255:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vtm_mem i_vtm_mem (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_stall(wr_stall), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_stall(rd_stall), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        is_wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic        stall;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 6'd0,  32'h0000_AAAA, 1'b0, 32'h0},          // R2
    '{1'b1, 6'd0,  32'h0000_BBBB, 1'b1, 32'h0},          // R3
    '{1'b0, 6'd0,  32'h0,         1'b0, 32'h0000_AAAA},  // R3 data kept, R4
    '{1'b0, 6'd0,  32'h0,         1'b1, 32'h0},          // R5
    '{1'b1, 6'd9,  32'h0000_1234, 1'b0, 32'h0},          // R2
    '{1'b0, 6'd9,  32'h0,         1'b0, 32'h0000_1234},  // R4
    '{1'b0, 6'd10, 32'h0,         1'b1, 32'h0},          // R6
    '{1'b1, 6'd0,  32'h0000_CCCC, 1'b0, 32'h0},          // R2 after consume
    '{1'b0, 6'd0,  32'h0,         1'b0, 32'h0000_CCCC}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_op(input logic [5:0] a, input logic [31:0] d, input logic exp_stall, input string req);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    #1 chk(req, 32'(wr_stall), 32'(exp_stall));
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic rd_op(input logic [5:0] a, input logic [2:0] l, input logic exp_stall,
                       input string req, output logic [255:0] got);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; rd_len = l;
    #1 chk(req, 32'(rd_stall), 32'(exp_stall));
    @(negedge clk);
    rd_req = 1'b0;
    #1 chk(req, 32'(rd_ack), 32'(!exp_stall));
    got = rd_data;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [255:0] got;
    rst_n = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_data = '0;
    rd_req = 1'b0; rd_addr = '0; rd_len = '0;
    #9 rst_n = 1'b1;

    // R1: every row stalls after reset
    for (int r = 0; r < 8; r++) begin
      rd_op(6'(r * 8), 3'd7, 1'b1, "R1", got);
    end

    // vector table
    for (int v = 0; v < 9; v++) begin
      if (VEC[v].is_wr) wr_op(VEC[v].addr, VEC[v].data, VEC[v].stall, "R2/R3 vector");
      else begin
        rd_op(VEC[v].addr, 3'd0, VEC[v].stall, "R4/R5/R6 vector", got);
        if (!VEC[v].stall) chk("R4 vector data", got[31:0], VEC[v].exp);
      end
    end

    // R7: full-row group starting at column 5 wraps inside row 2
    for (int a = 16; a < 24; a++) wr_op(6'(a), 32'hD000 + 32'(a), 1'b0, "R2 row fill");
    rd_op(6'd21, 3'd7, 1'b0, "R7", got);
    for (int i = 0; i < 8; i++) begin
      chk("R7 lane", got[i*32 +: 32], 32'hD000 + 32'(16 + ((5 + i) % 8)));
    end
    rd_op(6'd16, 3'd0, 1'b1, "R5 row consumed", got);

    // R6: partial group with one missing word
    for (int a = 24; a < 27; a++) wr_op(6'(a), 32'hE000 + 32'(a), 1'b0, "R2 part fill");
    rd_op(6'd24, 3'd3, 1'b1, "R6 missing word", got);
    rd_op(6'd24, 3'd2, 1'b0, "R6 flags kept", got);
    for (int i = 0; i < 3; i++) chk("R4 lane", got[i*32 +: 32], 32'hE000 + 32'(24 + i));
    for (int i = 3; i < 8; i++) chk("R4 idle lane zero", got[i*32 +: 32], 32'h0);

    // R8: same-cycle store and request to one invalid word
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 6'd40; wr_data = 32'h77;
    rd_req = 1'b1; rd_addr = 6'd40; rd_len = 3'd0;
    #1 chk("R8 read stalls", 32'(rd_stall), 32'd1);
    chk("R8 write accepted", 32'(wr_stall), 32'd0);
    @(negedge clk);
    wr_req = 1'b0;
    #1 chk("R8 read granted", 32'(rd_stall), 32'd0);
    @(negedge clk);
    rd_req = 1'b0;
    #1 chk("R8 ack", 32'(rd_ack), 32'd1);
    chk("R8 new data", rd_data[31:0], 32'h77);

    // R9: no stall without a request, even on a valid word
    wr_op(6'd50, 32'h5, 1'b0, "R2");
    @(negedge clk);
    wr_addr = 6'd50; rd_addr = 6'd51; rd_len = 3'd0;
    #1 chk("R9 wr_stall idle", 32'(wr_stall), 32'd0);
    chk("R9 rd_stall idle", 32'(rd_stall), 32'd0);
    wr_op(6'd50, 32'h6, 1'b1, "R3 still valid");

    finish_run();
  end
endmodule